// File: doc/BRIEF.md
# Real-Time Counter Interrupt Status and Mask Unit

This block sits next to a real-time counter and turns its events into interrupt request lines. Seven event sources feed a seven-bit sticky status register: the counter wrap strobe, two alarm-match strobes, rising edges on two software-selected prescaler taps, and the falling edges of two synchronization busy flags. The busy flags mark the end of a clock-domain handshake and of a register-write handshake. A seven-bit mask register decides which status bits may raise a request. The request lines are grouped by event kind, so that software can give each kind its own handler.

Software works through a small write port. One write selector value sets mask bits, another clears mask bits, and a third clears status bits. In each case only the data bits written as one take effect. A status bit stays set until software clears it. An event that arrives in the same cycle as the clear of its bit wins, so no event is lost. Edge detection uses a small two-state watcher per observed signal. Each watcher sits in `W_LOW` or `W_HIGH`. The transition `W_LOW -> W_HIGH` (signal seen high) produces the rising-edge hit in the rising variant. The transition `W_HIGH -> W_LOW` (signal seen low) produces the falling-edge hit in the falling variant.

Top module: `rtc_irq_hub`

## Requirements
- R1: The status and mask bit positions are: 0 wrap, 1 tap 0, 2 tap 1, 3 match 0, 4 match 1, 5 clock-sync done, 6 register-sync done. After a synchronous active-low reset, status, mask and all request lines are zero.
- R2: A write with `wr_sel`=0 sets every mask bit whose `wr_data` bit is one. A write with `wr_sel`=1 clears those mask bits. Zero data bits leave the mask unchanged, and `wr_sel`=3 has no effect.
- R3: `irq_wrap` equals status[0]&mask[0]. `irq_tick` is the OR of status&mask over bits 1..2. `irq_match` is the OR over bits 3..4. `irq_clk_sync` uses bit 5 and `irq_reg_sync` uses bit 6.
- R4: A status bit stays set until a write with `wr_sel`=2 has a one in its position. Zero data bits clear nothing.
- R5: Tap status bit n is set on a 0-to-1 transition of the prescaler bit chosen by tap selector n, and only while mask bit n+1 is one.
- R6: A prescaler tap held high sets its status only once. After a clear, the bit stays clear until the next rising edge.
- R7: Status bit 5 is set on a 1-to-0 transition of `clk_busy`, and status bit 6 on a 1-to-0 transition of `reg_busy`.
- R8: Status bit 0 is set by `wrap_stb`, and also by either match strobe while `wrap_on_match` is one. A match with `wrap_on_match` zero leaves bit 0 untouched.
- R9: `match0_stb` sets status bit 3 and `match1_stb` sets status bit 4. Status changes are visible one clock after the event.
- R10: When an event and a status clear hit the same bit in one cycle, the bit ends up set.
- R11: Each tap selector is a bit index into `presc_bits`. An edge on any other prescaler bit does not set that tap's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wrap_stb | input | 1 | Counter wrap strobe |
| match0_stb | input | 1 | Alarm 0 match strobe |
| match1_stb | input | 1 | Alarm 1 match strobe |
| wrap_on_match | input | 1 | Control bit: a match also counts as a wrap |
| presc_bits | input | PRESC_W | Prescaler bit vector |
| tap_sel0 | input | TAP_W | Prescaler bit index for tap 0 |
| tap_sel1 | input | TAP_W | Prescaler bit index for tap 1 |
| clk_busy | input | 1 | Clock synchronization busy flag |
| reg_busy | input | 1 | Register synchronization busy flag |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | 0 mask set, 1 mask clear, 2 status clear, 3 none |
| wr_data | input | 7 | Write data, one bit per source |
| irq_wrap | output | 1 | Wrap request |
| irq_tick | output | 1 | Periodic tap request |
| irq_match | output | 1 | Alarm request |
| irq_clk_sync | output | 1 | Clock sync done request |
| irq_reg_sync | output | 1 | Register sync done request |
| status_q | output | 7 | Status register |
| mask_q | output | 7 | Mask register |

## Verification
The assertions take for granted that the busy flags and prescaler bits are already synchronous to `clk`, and that reset is held from time zero. The single-hit and tap-gating properties also assume that a tap selector changes only while both the old and the new selected bits are low. Otherwise the switch itself looks like an edge. The stimulus changes every input just after a falling clock edge and moves the selectors only while the prescaler bits are zero. It issues exactly one write kind per cycle, because the write selector is one field.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int SRC_N     = 7;
    localparam int IDX_WRAP  = 0;
    localparam int IDX_TAP0  = 1;
    localparam int IDX_TAP1  = 2;
    localparam int IDX_M0    = 3;
    localparam int IDX_M1    = 4;
    localparam int IDX_CSYNC = 5;
    localparam int IDX_RSYNC = 6;
    localparam int TAP_N     = 2;

    typedef enum logic [1:0] {
        WR_MASK_SET = 2'd0,
        WR_MASK_CLR = 2'd1,
        WR_STAT_CLR = 2'd2,
        WR_NONE     = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/rtc_edge_watch.sv
module rtc_edge_watch #(
    parameter bit RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic hit
);
    typedef enum logic {W_LOW, W_HIGH} wst_e;
    wst_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            W_LOW:  if (din)  st_d = W_HIGH;
            W_HIGH: if (!din) st_d = W_LOW;
            default: st_d = W_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= W_LOW;
        else        st_q <= st_d;
    end

    generate
        if (RISE) begin : g_rise
            always_comb begin
                hit = 1'b0;
                unique case (st_q)
                    W_LOW:  hit = din;
                    W_HIGH: hit = 1'b0;
                    default: hit = 1'b0;
                endcase
            end
        end else begin : g_fall
            always_comb begin
                hit = 1'b0;
                unique case (st_q)
                    W_LOW:  hit = 1'b0;
                    W_HIGH: hit = !din;
                    default: hit = 1'b0;
                endcase
            end
        end
    endgenerate

    // R6: a level held after an edge gives no second hit
    p_single_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/rtc_irq_mask.sv
module rtc_irq_mask #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] en_v,
    input  logic [N-1:0] dis_v,
    output logic [N-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= (mask_q | en_v) & ~dis_v;
    end

    p_zero_write_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_v == '0 && dis_v == '0) |=> $stable(mask_q));

    p_enable_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_v == '0) |=> ((mask_q & $past(en_v)) == $past(en_v)));
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] st_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr_v) | set_v;
    end

    p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & $past(st_q & ~clr_v)) == $past(st_q & ~clr_v)));

    p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((st_q & $past(set_v)) == $past(set_v)));
endmodule

// File: rtl/rtc_irq_hub.sv
module rtc_irq_hub
    import rtc_irq_pkg::*;
#(
    parameter int PRESC_W = 32,
    localparam int TAP_W  = $clog2(PRESC_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wrap_stb,
    input  logic               match0_stb,
    input  logic               match1_stb,
    input  logic               wrap_on_match,
    input  logic [PRESC_W-1:0] presc_bits,
    input  logic [TAP_W-1:0]   tap_sel0,
    input  logic [TAP_W-1:0]   tap_sel1,
    input  logic               clk_busy,
    input  logic               reg_busy,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [SRC_N-1:0]   wr_data,
    output logic               irq_wrap,
    output logic               irq_tick,
    output logic               irq_match,
    output logic               irq_clk_sync,
    output logic               irq_reg_sync,
    output logic [SRC_N-1:0]   status_q,
    output logic [SRC_N-1:0]   mask_q
);
    wr_kind_e             wkind;
    logic [SRC_N-1:0]     mask_en_v, mask_dis_v, stat_clr_v, stat_set_v;
    logic [TAP_W-1:0]     tap_sel [TAP_N];
    logic [TAP_N-1:0]     tap_lvl, tap_hit;
    logic                 csync_hit, rsync_hit;

    assign wkind      = wr_kind_e'(wr_sel);
    assign mask_en_v  = (wr_en && wkind == WR_MASK_SET) ? wr_data : '0;
    assign mask_dis_v = (wr_en && wkind == WR_MASK_CLR) ? wr_data : '0;
    assign stat_clr_v = (wr_en && wkind == WR_STAT_CLR) ? wr_data : '0;

    assign tap_sel[0] = tap_sel0;
    assign tap_sel[1] = tap_sel1;

    generate
        for (genvar t = 0; t < TAP_N; t++) begin : g_tap
            assign tap_lvl[t] = presc_bits[tap_sel[t]];
            rtc_edge_watch #(.RISE(1'b1)) u_tap_watch (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (tap_lvl[t]),
                .hit  (tap_hit[t])
            );
        end
    endgenerate

    rtc_edge_watch #(.RISE(1'b0)) u_csync_watch (
        .clk(clk), .rst_n(rst_n), .din(clk_busy), .hit(csync_hit)
    );
    rtc_edge_watch #(.RISE(1'b0)) u_rsync_watch (
        .clk(clk), .rst_n(rst_n), .din(reg_busy), .hit(rsync_hit)
    );

    always_comb begin
        stat_set_v            = '0;
        stat_set_v[IDX_WRAP]  = wrap_stb | (wrap_on_match & (match0_stb | match1_stb));
        stat_set_v[IDX_TAP0]  = tap_hit[0] & mask_q[IDX_TAP0];
        stat_set_v[IDX_TAP1]  = tap_hit[1] & mask_q[IDX_TAP1];
        stat_set_v[IDX_M0]    = match0_stb;
        stat_set_v[IDX_M1]    = match1_stb;
        stat_set_v[IDX_CSYNC] = csync_hit;
        stat_set_v[IDX_RSYNC] = rsync_hit;
    end

    rtc_irq_mask #(.N(SRC_N)) u_mask (
        .clk(clk), .rst_n(rst_n), .en_v(mask_en_v), .dis_v(mask_dis_v), .mask_q(mask_q)
    );

    rtc_irq_status #(.N(SRC_N)) u_status (
        .clk(clk), .rst_n(rst_n), .set_v(stat_set_v), .clr_v(stat_clr_v), .st_q(status_q)
    );

    logic [SRC_N-1:0] live;
    assign live         = status_q & mask_q;
    assign irq_wrap     = live[IDX_WRAP];
    assign irq_tick     = live[IDX_TAP0] | live[IDX_TAP1];
    assign irq_match    = live[IDX_M0] | live[IDX_M1];
    assign irq_clk_sync = live[IDX_CSYNC];
    assign irq_reg_sync = live[IDX_RSYNC];

    // R5: a masked tap cannot gain status
    p_tap0_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_q[IDX_TAP0] && !status_q[IDX_TAP0]) |=> !status_q[IDX_TAP0]);
    p_tap1_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_q[IDX_TAP1] && !status_q[IDX_TAP1]) |=> !status_q[IDX_TAP1]);
    // R9: a match strobe is recorded on the next cycle
    p_match_recorded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match0_stb |=> status_q[IDX_M0]);
endmodule

// File: tb/rtc_irq_hub_bench.sv
`timescale 1ns/1ps
module rtc_irq_hub_bench;
    localparam int PW = 32;
    localparam int TW = $clog2(PW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wrap_stb = 0, match0_stb = 0, match1_stb = 0, wrap_on_match = 0;
    logic [PW-1:0] presc_bits = '0;
    logic [TW-1:0] tap_sel0 = '0, tap_sel1 = '0;
    logic clk_busy = 0, reg_busy = 0, wr_en = 0;
    logic [1:0] wr_sel = 2'd3;
    logic [6:0] wr_data = '0;
    logic irq_wrap, irq_tick, irq_match, irq_clk_sync, irq_reg_sync;
    logic [6:0] status_q, mask_q;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rtc_irq_hub #(.PRESC_W(PW)) u_rtc_irq_hub (
        .clk(clk), .rst_n(rst_n), .wrap_stb(wrap_stb), .match0_stb(match0_stb),
        .match1_stb(match1_stb), .wrap_on_match(wrap_on_match), .presc_bits(presc_bits),
        .tap_sel0(tap_sel0), .tap_sel1(tap_sel1), .clk_busy(clk_busy), .reg_busy(reg_busy),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq_wrap(irq_wrap),
        .irq_tick(irq_tick), .irq_match(irq_match), .irq_clk_sync(irq_clk_sync),
        .irq_reg_sync(irq_reg_sync), .status_q(status_q), .mask_q(mask_q)
    );

    typedef struct packed {
        logic       we;
        logic [1:0] ws;
        logic [6:0] wd;
        logic       ov, a0, a1, cb, rb, wom;
        logic [6:0] es;
        logic [6:0] em;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VT [NV] = '{
        '{1'b1, 2'd0, 7'h7F, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'h00, 7'h7F, 4'd2},  // R2 enable all
        '{1'b0, 2'd3, 7'h00, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 7'h08, 7'h7F, 4'd8},  // R8 match, no wrap
        '{1'b0, 2'd3, 7'h00, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 7'h19, 7'h7F, 4'd9},  // R9 match1 + wrap
        '{1'b1, 2'd2, 7'h01, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'h18, 7'h7F, 4'd4},  // R4 clear bit 0
        '{1'b0, 2'd3, 7'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 7'h19, 7'h7F, 4'd8},  // R8 wrap strobe
        '{1'b0, 2'd3, 7'h00, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 7'h19, 7'h7F, 4'd7},  // R7 clk busy up
        '{1'b0, 2'd3, 7'h00, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 7'h39, 7'h7F, 4'd7},  // R7 clk busy falls
        '{1'b0, 2'd3, 7'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'h79, 7'h7F, 4'd7},  // R7 reg busy falls
        '{1'b1, 2'd2, 7'h09, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'h70, 7'h7F, 4'd4},  // R4 clear two
        '{1'b1, 2'd2, 7'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 7'h71, 7'h7F, 4'd4},  // R4 zero clear
        '{1'b1, 2'd1, 7'h01, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'h71, 7'h7E, 4'd2},  // R2 disable bit 0
        '{1'b1, 2'd2, 7'h01, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 7'h71, 7'h7E, 4'd10}, // R10 set wins
        '{1'b1, 2'd3, 7'h7F, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'h71, 7'h7E, 4'd2},  // R2 sel 3 inert
        '{1'b1, 2'd2, 7'h7F, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'h00, 7'h7E, 4'd4},  // R4 clear all
        '{1'b1, 2'd0, 7'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'h00, 7'h7E, 4'd2}   // R2 zero enable
    };

    task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(input string tag, input logic [6:0] es, input logic [6:0] em);
        logic [6:0] lv;
        lv = es & em;
        chk(tag, {2'b0, irq_reg_sync, irq_clk_sync, irq_match, irq_tick, irq_wrap},
                 {2'b0, lv[6], lv[5], lv[4] | lv[3], lv[2] | lv[1], lv[0]});
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus(input logic [1:0] s, input logic [6:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        step();
        wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R1 reset status", status_q, 7'h00);
        chk("R1 reset mask", mask_q, 7'h00);
        chk_irq("R1 reset irq", 7'h00, 7'h00);

        for (int i = 0; i < NV; i++) begin
            wr_en = VT[i].we; wr_sel = VT[i].ws; wr_data = VT[i].wd;
            wrap_stb = VT[i].ov; match0_stb = VT[i].a0; match1_stb = VT[i].a1;
            clk_busy = VT[i].cb; reg_busy = VT[i].rb; wrap_on_match = VT[i].wom;
            step();
            chk($sformatf("R%0d vec%0d status", VT[i].req, i), status_q, VT[i].es);
            chk($sformatf("R%0d vec%0d mask", VT[i].req, i), mask_q, VT[i].em);
            chk_irq($sformatf("R3 vec%0d irq", i), VT[i].es, VT[i].em);
        end
        wr_en = 0; wr_sel = 2'd3; wr_data = '0; wrap_stb = 0; match0_stb = 0;
        match1_stb = 0; clk_busy = 0; reg_busy = 0; wrap_on_match = 0;

        // R5: masked tap edge ignored
        bus(2'd1, 7'h7F);
        tap_sel0 = 5'd3; tap_sel1 = 5'd5;
        step();
        presc_bits[3] = 1'b1;
        step();
        chk("R5 masked tap", status_q, 7'h00);
        presc_bits[3] = 1'b0;
        step();
        bus(2'd0, 7'h02);
        presc_bits[3] = 1'b1;
        step();
        chk("R5 tap0 edge", status_q, 7'h02);
        chk_irq("R3 tap0 irq", 7'h02, 7'h02);
        // R6: held level, clear, no re-set
        step();
        bus(2'd2, 7'h02);
        chk("R6 cleared", status_q, 7'h00);
        step(); step();
        chk("R6 held high no reset", status_q, 7'h00);

        // R11: edge on a non-selected bit
        bus(2'd0, 7'h04);
        presc_bits = '0;
        presc_bits[4] = 1'b1;
        step();
        chk("R11 other bit ignored", status_q, 7'h00);
        presc_bits[5] = 1'b1;
        step();
        chk("R11 selected bit", status_q, 7'h04);

        // R3: status without mask gives no request
        match0_stb = 1'b1;
        step();
        match0_stb = 1'b0;
        chk("R9 match0 status", status_q, 7'h0C);
        chk_irq("R3 match unmasked", 7'h0C, 7'h06);
        bus(2'd0, 7'h08);
        chk_irq("R3 match masked in", 7'h0C, 7'h0E);

        finish_run();
    end
endmodule